// File: doc/BRIEF.md
# Current Fault Retry Controller

This block decides when the battery protection switches may close again after a current fault such as a short circuit. A single-cycle fault pulse opens the discharge switch enable at once, and opens the charge switch enable too when configured to do so. After a programmable hold-off the block closes the switches again. If faults keep recurring, a retry counter stops automatic recovery after a programmed number of attempts. The switches then stay open until the load has been taken away or a host clears the lockout.

Load removal is sensed through a charge-pin-high detector bit. While the switches are locked open and a load is attached, the charge pin is pulled high. When the pack is pulled out, the pin drops low. The block keeps a debounced copy of this detector. A falling edge of that copy releases the lockout. Any change of the debounced copy can also pulse an alert line. A small status port shows the raw detector bit and the debounced copy side by side.

Top module: `fault_retry_ctrl`

## Requirements
- R1: When a fault pulse is sampled at a clock edge, `dsg_en_o` is low after that same edge.
- R2: `chg_en_o` goes low on a fault only if `cfg_drop_chg_i` is 1 when the fault that opens the switches is sampled. Otherwise it stays high.
- R3: With hold-off value D, the enables stay open for exactly D+1 cycles after the fault edge and then return high. A new fault during the hold-off restarts the full D+1 count.
- R4: Each automatic re-close adds one to a retry count. With a nonzero limit L, a fault that arrives while the count equals L locks the switches open. They stay open for any length of time, whatever further faults arrive.
- R5: A limit of 0 allows unlimited retries, and the lockout never engages. With a nonzero limit, the count never exceeds the limit.
- R6: If the switches stay closed without a fault for D+1 cycles after a re-close, the retry count returns to 0.
- R7: `status_o[0]` is the raw detector input and `status_o[1]` is the debounced flag. The flag takes the raw value only after N consecutive differing samples (N = `cfg_dbnc_i`, where 0 acts as 1). Shorter glitches leave it unchanged. After reset the flag is 0.
- R8: When `cfg_alert_en_i` is 1, `alert_o` is high for exactly one cycle, in the cycle the debounced flag changes in either direction. When it is 0, `alert_o` stays low.
- R9: In lockout, a falling edge of the debounced flag closes the switches one cycle after the flag falls, and the retry count returns to 0.
- R10: A `clr_latch_i` strobe puts the block back in the closed state with a zero retry count, from any state. It takes priority over a fault sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Current fault event pulse |
| det_raw_i | input | 1 | Raw charge-pin-high detector bit |
| cfg_delay_i | input | DLY_W | Hold-off length D in cycles (open time is D+1) |
| cfg_limit_i | input | CNT_W | Retry limit, 0 = unlimited |
| cfg_drop_chg_i | input | 1 | Also open the charge switch on a fault |
| cfg_alert_en_i | input | 1 | Enable alert pulses on debounced flag changes |
| cfg_dbnc_i | input | DB_W | Debounce sample count N |
| clr_latch_i | input | 1 | Host strobe: clear lockout and retry count |
| dsg_en_o | output | 1 | Discharge switch enable |
| chg_en_o | output | 1 | Charge switch enable |
| alert_o | output | 1 | Alert pulse |
| status_o | output | 2 | {debounced flag, raw flag} |

## Verification
Some rules are checked by assertions on every cycle: a fault opens the discharge switch on the next edge, a charge-switch enable with dropping disabled survives a fault, a lockout holds while neither release source is present, the retry count stays within a nonzero limit, and each change of the debounced flag brings exactly its alert pulse. Other behaviour shows only in the bench scenarios. These include the exact D+1 hold-off length and its restart, the count of retries before lockout, the count reset after a quiet period, unlimited retries, glitch rejection at the debounce length, and release by load removal or host strobe.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        ST_ON         = 2'd0,
        ST_FAULT_WAIT = 2'd1,
        ST_RETRY      = 2'd2,
        ST_LATCHED    = 2'd3
    } frc_state_e;

    typedef struct packed {
        logic dsg;
        logic chg;
    } sw_en_t;

    typedef struct packed {
        logic deb;
        logic raw;
    } det_flags_t;

    // Switches are closed in the steady and retry states.
    function automatic logic sw_closed(frc_state_e st);
        return (st == ST_ON) || (st == ST_RETRY);
    endfunction

    // Load removal seen: debounced flag just toggled to 0.
    function automatic logic load_gone(logic tgl, logic deb);
        return tgl && !deb;
    endfunction

endpackage

// File: rtl/frc_debounce.sv
module frc_debounce #(
    parameter int DB_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_i,
    input  logic [DB_W-1:0] len_i,
    output logic            flag_o,
    output logic            tgl_o
);
    localparam int CW = DB_W + 1;

    logic [DB_W-1:0] run_q;
    logic [CW-1:0]   eff_len;
    logic [CW-1:0]   run_nxt;

    always_comb begin
        eff_len = (len_i == '0) ? CW'(1) : CW'(len_i);
        run_nxt = CW'(run_q) + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            tgl_o  <= 1'b0;
            run_q  <= '0;
        end else if (raw_i == flag_o) begin
            tgl_o  <= 1'b0;
            run_q  <= '0;
        end else if (run_nxt >= eff_len) begin
            flag_o <= raw_i;
            tgl_o  <= 1'b1;
            run_q  <= '0;
        end else begin
            tgl_o  <= 1'b0;
            run_q  <= run_nxt[DB_W-1:0];
        end
    end
endmodule

// File: rtl/frc_delay_timer.sv
module frc_delay_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [DLY_W-1:0] len_i,
    output logic             done_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/frc_retry_fsm.sv
module frc_retry_fsm
    import frc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_i,
    input  logic             clr_i,
    input  logic             drop_chg_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             release_i,
    input  logic             tmr_done_i,
    output logic             tmr_load_o,
    output logic             tmr_run_o,
    output frc_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output sw_en_t           sw_o
);
    frc_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             chg_off_q, chg_off_d;
    logic             limit_hit;

    assign limit_hit = (limit_i != '0) && (cnt_q >= limit_i);

    always_comb begin
        st_d       = st_q;
        cnt_d      = cnt_q;
        chg_off_d  = chg_off_q;
        tmr_load_o = 1'b0;
        tmr_run_o  = (st_q == ST_FAULT_WAIT) || (st_q == ST_RETRY);
        if (clr_i) begin
            st_d      = ST_ON;
            cnt_d     = '0;
            chg_off_d = 1'b0;
        end else begin
            unique case (st_q)
                ST_ON, ST_RETRY: begin
                    if (fault_i) begin
                        st_d       = limit_hit ? ST_LATCHED : ST_FAULT_WAIT;
                        chg_off_d  = drop_chg_i;
                        tmr_load_o = 1'b1;
                    end else if (st_q == ST_RETRY && tmr_done_i) begin
                        st_d  = ST_ON;
                        cnt_d = '0;
                    end
                end
                ST_FAULT_WAIT: begin
                    if (fault_i) begin
                        tmr_load_o = 1'b1;
                    end else if (tmr_done_i) begin
                        st_d       = ST_RETRY;
                        tmr_load_o = 1'b1;
                        cnt_d      = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);
                    end
                end
                ST_LATCHED: begin
                    if (release_i) begin
                        st_d      = ST_ON;
                        cnt_d     = '0;
                        chg_off_d = 1'b0;
                    end
                end
                default: st_d = ST_ON;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_ON;
            cnt_q     <= '0;
            chg_off_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            chg_off_q <= chg_off_d;
        end
    end

    always_comb begin
        sw_o.dsg = sw_closed(st_q);
        sw_o.chg = sw_closed(st_q) || !chg_off_q;
    end

    assign state_o = st_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl
    import frc_pkg::*;
#(
    parameter int DLY_W = 16,
    parameter int CNT_W = 4,
    parameter int DB_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_i,
    input  logic             det_raw_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    input  logic [CNT_W-1:0] cfg_limit_i,
    input  logic             cfg_drop_chg_i,
    input  logic             cfg_alert_en_i,
    input  logic [DB_W-1:0]  cfg_dbnc_i,
    input  logic             clr_latch_i,
    output logic             dsg_en_o,
    output logic             chg_en_o,
    output logic             alert_o,
    output logic [1:0]       status_o
);
    logic             det_deb;
    logic             det_tgl;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_done;
    frc_state_e       state;
    logic [CNT_W-1:0] retry_cnt;
    sw_en_t           sw;
    det_flags_t       flags;

    frc_debounce #(.DB_W(DB_W)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (det_raw_i),
        .len_i  (cfg_dbnc_i),
        .flag_o (det_deb),
        .tgl_o  (det_tgl)
    );

    frc_delay_timer #(.DLY_W(DLY_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .run_i  (tmr_run),
        .len_i  (cfg_delay_i),
        .done_o (tmr_done)
    );

    frc_retry_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fault_i    (fault_i),
        .clr_i      (clr_latch_i),
        .drop_chg_i (cfg_drop_chg_i),
        .limit_i    (cfg_limit_i),
        .release_i  (load_gone(det_tgl, det_deb)),
        .tmr_done_i (tmr_done),
        .tmr_load_o (tmr_load),
        .tmr_run_o  (tmr_run),
        .state_o    (state),
        .cnt_o      (retry_cnt),
        .sw_o       (sw)
    );

    always_comb begin
        flags.deb = det_deb;
        flags.raw = det_raw_i;
    end

    assign dsg_en_o = sw.dsg;
    assign chg_en_o = sw.chg;
    assign alert_o  = det_tgl && cfg_alert_en_i;
    assign status_o = flags;
endmodule

// File: rtl/frc_checker.sv
module frc_checker
    import frc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             fault_i,
    input logic             clr_latch_i,
    input logic             cfg_drop_chg_i,
    input logic             cfg_alert_en_i,
    input logic [CNT_W-1:0] cfg_limit_i,
    input logic             dsg_en_o,
    input logic             chg_en_o,
    input logic             alert_o,
    input logic             deb_i,
    input logic             tgl_i,
    input frc_state_e       state_i,
    input logic [CNT_W-1:0] cnt_i
);
    a_r1_fault_opens_dsg: assert property (@(posedge clk) disable iff (rst)
        (fault_i && !clr_latch_i) |=> !dsg_en_o);

    a_r2_chg_kept_when_not_dropped: assert property (@(posedge clk) disable iff (rst)
        (dsg_en_o && chg_en_o && fault_i && !clr_latch_i && !cfg_drop_chg_i) |=> chg_en_o);

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_LATCHED && !clr_latch_i && !(tgl_i && !deb_i))
        |=> (state_i == ST_LATCHED && !dsg_en_o));

    a_r5_count_within_limit: assert property (@(posedge clk) disable iff (rst)
        (cfg_limit_i != '0 && $stable(cfg_limit_i)) |-> (cnt_i <= cfg_limit_i));

    a_r8_alert_on_change: assert property (@(posedge clk) disable iff (rst)
        (deb_i != $past(deb_i) && cfg_alert_en_i) |-> alert_o);

    a_r8_alert_only_on_change: assert property (@(posedge clk) disable iff (rst)
        alert_o |-> (deb_i != $past(deb_i)));
endmodule

bind fault_retry_ctrl frc_checker #(.CNT_W(CNT_W)) u_frc_chk (
    .clk            (clk),
    .rst            (rst),
    .fault_i        (fault_i),
    .clr_latch_i    (clr_latch_i),
    .cfg_drop_chg_i (cfg_drop_chg_i),
    .cfg_alert_en_i (cfg_alert_en_i),
    .cfg_limit_i    (cfg_limit_i),
    .dsg_en_o       (dsg_en_o),
    .chg_en_o       (chg_en_o),
    .alert_o        (alert_o),
    .deb_i          (det_deb),
    .tgl_i          (det_tgl),
    .state_i        (state),
    .cnt_i          (retry_cnt)
);

// File: tb/test_fault_retry_ctrl.sv
`timescale 1ns/1ps
module test_fault_retry_ctrl;
    localparam int DLY_W = 16;
    localparam int CNT_W = 4;
    localparam int DB_W  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fault_i = 1'b0;
    logic             det_raw_i = 1'b0;
    logic [DLY_W-1:0] cfg_delay_i = '0;
    logic [CNT_W-1:0] cfg_limit_i = '0;
    logic             cfg_drop_chg_i = 1'b0;
    logic             cfg_alert_en_i = 1'b0;
    logic [DB_W-1:0]  cfg_dbnc_i = '0;
    logic             clr_latch_i = 1'b0;
    logic             dsg_en_o, chg_en_o, alert_o;
    logic [1:0]       status_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fault_retry_ctrl #(.DLY_W(DLY_W), .CNT_W(CNT_W), .DB_W(DB_W)) i_fault_retry_ctrl (
        .clk(clk), .rst(rst), .fault_i(fault_i), .det_raw_i(det_raw_i),
        .cfg_delay_i(cfg_delay_i), .cfg_limit_i(cfg_limit_i),
        .cfg_drop_chg_i(cfg_drop_chg_i), .cfg_alert_en_i(cfg_alert_en_i),
        .cfg_dbnc_i(cfg_dbnc_i), .clr_latch_i(clr_latch_i),
        .dsg_en_o(dsg_en_o), .chg_en_o(chg_en_o), .alert_o(alert_o),
        .status_o(status_o)
    );

    function automatic int open_cycles(int d);
        return d + 1;
    endfunction

    function automatic int eff_dbnc(int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_fault();
        fault_i = 1'b1;
        tick();
        fault_i = 1'b0;
    endtask

    task automatic host_clear();
        clr_latch_i = 1'b1;
        tick();
        clr_latch_i = 1'b0;
    endtask

    // Counts cycles until dsg_en_o returns high, capped.
    task automatic measure_open(output int n);
        n = 0;
        while (!dsg_en_o && n < 1000) begin
            tick();
            n++;
        end
    endtask

    initial begin
        int n;
        int d;
        void'($urandom(32'd2718));
        repeat (3) tick();
        rst = 1'b0;
        tick();

        check(dsg_en_o && chg_en_o && !alert_o && status_o == 2'b00,
              "reset state", {dsg_en_o, chg_en_o, alert_o, status_o}, 5'b11000);

        // R1, R2: charge enable kept when dropping disabled
        cfg_delay_i = 16'd4; cfg_limit_i = 4'd0; cfg_drop_chg_i = 1'b0;
        pulse_fault();
        check(!dsg_en_o, "R1 dsg open after fault", dsg_en_o, 0);
        check(chg_en_o, "R2 chg kept without drop", chg_en_o, 1);
        measure_open(n);
        check(n == open_cycles(4), "R3 open length d=4", n, open_cycles(4));

        // R2: charge enable dropped
        repeat (8) tick();
        cfg_drop_chg_i = 1'b1;
        pulse_fault();
        check(!chg_en_o, "R2 chg open with drop", chg_en_o, 0);
        measure_open(n);
        check(chg_en_o, "R2 chg closed after retry", chg_en_o, 1);

        // R3: random hold-off lengths
        for (int i = 0; i < 6; i++) begin
            repeat (12) tick();
            d = int'($urandom_range(0, 9));
            cfg_delay_i = DLY_W'(d);
            pulse_fault();
            measure_open(n);
            check(n == open_cycles(d), "R3 random open length", n, open_cycles(d));
        end

        // R3: fault during hold-off restarts it
        repeat (12) tick();
        cfg_delay_i = 16'd5;
        pulse_fault();
        repeat (3) tick();
        pulse_fault();
        measure_open(n);
        check(n == open_cycles(5), "R3 restart on refault", n, open_cycles(5));

        // R4: limit 2, back-to-back faults lock out on the third
        repeat (12) tick();
        cfg_delay_i = 16'd3; cfg_limit_i = 4'd2; cfg_drop_chg_i = 1'b1;
        host_clear();
        pulse_fault(); measure_open(n);
        pulse_fault(); measure_open(n);
        check(n == open_cycles(3), "R4 second retry allowed", n, open_cycles(3));
        pulse_fault();
        repeat (40) tick();
        check(!dsg_en_o && !chg_en_o, "R4 locked open", {dsg_en_o, chg_en_o}, 0);
        pulse_fault();
        repeat (20) tick();
        check(!dsg_en_o, "R4 still locked after fault", dsg_en_o, 0);

        // R7, R8: load present -> debounced flag rises, alert pulses
        cfg_dbnc_i = 4'd3; cfg_alert_en_i = 1'b1;
        det_raw_i = 1'b1;
        tick();
        check(status_o == 2'b01, "R7 raw visible, deb not yet", status_o, 1);
        tick();
        check(status_o[1] == 1'b0 && !alert_o, "R7 deb held at 2 samples", status_o, 1);
        tick();
        check(status_o[1] == 1'b1, "R7 deb rises at 3 samples", status_o, 3);
        check(alert_o, "R8 alert on rise", alert_o, 1);
        tick();
        check(!alert_o, "R8 alert one cycle", alert_o, 0);
        check(!dsg_en_o, "R9 rise does not release", dsg_en_o, 0);

        // R7: glitch shorter than N ignored
        det_raw_i = 1'b0;
        repeat (2) tick();
        det_raw_i = 1'b1;
        tick();
        check(status_o[1] == 1'b1 && !alert_o, "R7 glitch rejected", status_o, 3);
        check(!dsg_en_o, "R7 glitch leaves lockout", dsg_en_o, 0);

        // R9: load removed -> release one cycle after deb falls
        det_raw_i = 1'b0;
        repeat (3) tick();
        check(status_o[1] == 1'b0 && alert_o, "R9 deb fell with alert", status_o, 0);
        check(!dsg_en_o, "R9 still open in fall cycle", dsg_en_o, 0);
        tick();
        check(dsg_en_o && chg_en_o, "R9 released", {dsg_en_o, chg_en_o}, 3);
        // count was cleared: two retries available again
        pulse_fault(); measure_open(n);
        check(n == open_cycles(3), "R9 count cleared", n, open_cycles(3));

        // R6: quiet period resets count (limit 1)
        repeat (12) tick();
        cfg_limit_i = 4'd1;
        host_clear();
        pulse_fault(); measure_open(n);
        repeat (open_cycles(3) + 2) tick();
        pulse_fault(); measure_open(n);
        check(n == open_cycles(3), "R6 count reset after quiet", n, open_cycles(3));

        // R10: lockout then clear strobe with simultaneous fault
        pulse_fault();
        repeat (20) tick();
        check(!dsg_en_o, "R4 limit 1 lockout", dsg_en_o, 0);
        fault_i = 1'b1; clr_latch_i = 1'b1;
        tick();
        fault_i = 1'b0; clr_latch_i = 1'b0;
        check(dsg_en_o && chg_en_o, "R10 clear beats fault", {dsg_en_o, chg_en_o}, 3);
        pulse_fault(); measure_open(n);
        check(n == open_cycles(3), "R10 count zero after clear", n, open_cycles(3));

        // R5: unlimited retries
        cfg_limit_i = 4'd0; cfg_delay_i = 16'd2;
        host_clear();
        for (int i = 0; i < 20; i++) begin
            pulse_fault();
            measure_open(n);
            check(n == open_cycles(2), "R5 unlimited retry", n, open_cycles(2));
        end

        // R8: alert disabled, random debounce lengths
        cfg_alert_en_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            int nn;
            int g;
            bit seen;
            nn = int'($urandom_range(0, 6));
            cfg_dbnc_i = DB_W'(nn);
            g = eff_dbnc(nn) - 1;
            seen = 0;
            det_raw_i = ~status_o[1];
            for (int k = 0; k < g; k++) begin
                tick();
                seen |= alert_o;
            end
            check(status_o[1] != det_raw_i, "R7 no change before N", status_o[1], !det_raw_i);
            tick();
            seen |= alert_o;
            check(status_o[1] == det_raw_i, "R7 change at N", status_o[1], det_raw_i);
            check(!seen, "R8 no alert when disabled", seen, 0);
            repeat (3) tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule